// File: doc/BRIEF.md
# Saturating Double-and-Accumulate Unit

This block is an execute-stage datapath for signed fixed-point arithmetic. It takes two signed operands, doubles the second one with saturation, and then adds that value to the first operand or subtracts it from the first operand. The sum or difference is saturated again. An opcode input selects add or subtract. An execute-enable input stands in for an already evaluated condition code.

The result and a write-enable are registered, so they appear one clock after the operands. Any clamp at either stage sets a sticky saturation flag. The flag stays set until a separate clear strobe resets it. If a clear and a new saturation arrive in the same cycle, the saturation wins.

Top module: `sat_dbl_acc`

## Requirements
- R1: After reset (rst_ni low), res_o is 0, we_o is 0 and q_o is 0.
- R2: The doubled second operand is 2*opb_i. It overflows when opb_i[31] differs from opb_i[30]. On overflow it clamps to 0x7FFFFFFF if opb_i is non-negative, and to 0x80000000 if opb_i is negative.
- R3: When op_sub_i is 0, the result is opa_i plus the clamped doubled value.
- R4: When op_sub_i is 1, the result is opa_i minus the clamped doubled value.
- R5: The sum or difference is formed at 33 bits. It is clamped to the range -2^31..2^31-1, toward the sign of that 33-bit value.
- R6: If exec_i is high at a rising edge, res_o takes the result and we_o is 1 after that edge. If exec_i is low, we_o is 0 after that edge.
- R7: If exec_i is low at a rising edge, res_o keeps its value and q_o does not become set.
- R8: If exec_i is high and either stage clamps, q_o is 1 after that edge. q_o is sticky: once set, it stays 1 until cleared.
- R9: If q_clr_i is high at an edge with no executed saturation, q_o becomes 0. If a saturation is executed in the same cycle as a clear, q_o becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute enable (condition passed) |
| op_sub_i | input | 1 | 0 = add, 1 = subtract |
| opa_i | input | 32 | First operand (signed) |
| opb_i | input | 32 | Second operand (signed), doubled |
| q_clr_i | input | 1 | Synchronous clear of the saturation flag |
| res_o | output | 32 | Registered result |
| we_o | output | 1 | Registered write enable |
| q_o | output | 1 | Sticky saturation flag |

## Verification
A fault in the doubler or in the add/subtract stage shows up on res_o one cycle after the operands are presented. A faulty clamp decision also shows on q_o at that same edge. A wrong flag register can be seen on q_o in two ways: the flag drops with no clear, or it survives a clear that had no saturation in the same cycle. A missing hold shows as res_o changing or we_o rising after an edge where exec_i was low.

// File: rtl/sat_dbl_pkg.sv
package sat_dbl_pkg;
  typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} op_e;
endpackage

// File: rtl/sat_doubler.sv
module sat_doubler #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] dbl_o,
  output logic         sat_o
);
  localparam logic [W-1:0] MaxV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MinV = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    sat_o = val_i[W-1] ^ val_i[W-2];
    if (sat_o) dbl_o = val_i[W-1] ? MinV : MaxV;
    else       dbl_o = {val_i[W-2:0], 1'b0};
  end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub
  import sat_dbl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] d_i,
  input  op_e          op_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  localparam logic [W-1:0] MaxV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MinV = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ext_a, ext_d, wide;

  always_comb begin
    ext_a = {a_i[W-1], a_i};
    ext_d = {d_i[W-1], d_i};
    wide  = (op_i == OP_SUB) ? ext_a - ext_d : ext_a + ext_d;
    sat_o = wide[W] ^ wide[W-1];
    if (sat_o) res_o = wide[W] ? MinV : MaxV;
    else       res_o = wide[W-1:0];
  end
endmodule

// File: rtl/sat_flag.sv
module sat_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;  // set beats clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/sat_dbl_acc.sv
module sat_dbl_acc
  import sat_dbl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         exec_i,
  input  logic         op_sub_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         q_clr_i,
  output logic [W-1:0] res_o,
  output logic         we_o,
  output logic         q_o
);
  logic [W-1:0] dbl, res_d;
  logic         dbl_sat, as_sat, sat_set;
  op_e          op;

  assign op = op_sub_i ? OP_SUB : OP_ADD;

  sat_doubler #(.W(W)) u_dbl (.val_i(opb_i), .dbl_o(dbl), .sat_o(dbl_sat));

  sat_addsub #(.W(W)) u_as (
    .a_i(opa_i), .d_i(dbl), .op_i(op), .res_o(res_d), .sat_o(as_sat)
  );

  assign sat_set = exec_i & (dbl_sat | as_sat);

  sat_flag u_q (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(sat_set), .clr_i(q_clr_i), .q_o(q_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      we_o  <= 1'b0;
    end else begin
      we_o <= exec_i;
      if (exec_i) res_o <= res_d;
    end
  end

  a_r6_we_follows_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> we_o);
  a_r7_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> ($stable(res_o) && !we_o));
  a_r8_sat_sets_q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && (dbl_sat || as_sat)) |=> q_o);
  a_r8_q_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !q_clr_i) |=> q_o);
  a_r9_clear_q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_clr_i && !sat_set) |=> !q_o);
  a_r2_dbl_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbl_sat |-> (dbl[W-1] == opb_i[W-1]));
endmodule

// File: tb/sat_dbl_acc_tb_top.sv
module sat_dbl_acc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec = 1'b0, sub = 1'b0, clr = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] res;
  logic        we, q;

  int errors = 0, checks = 0;
  logic [31:0] exp_res = '0;
  logic        exp_q = 1'b0;

  always #2.5 clk = ~clk;

  sat_dbl_acc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .op_sub_i(sub),
    .opa_i(a), .opb_i(b), .q_clr_i(clr), .res_o(res), .we_o(we), .q_o(q)
  );

  function automatic longint clamp(input longint v, output logic s);
    s = 1'b0;
    if (v > 64'sd2147483647)       begin s = 1'b1; return 64'sd2147483647; end
    else if (v < -64'sd2147483648) begin s = 1'b1; return -64'sd2147483648; end
    return v;
  endfunction

  function automatic void model(input logic [31:0] ai, bi, input logic si,
                                output logic [31:0] r, output logic s);
    longint d, t;
    logic s1, s2;
    d = clamp(2 * longint'($signed(bi)), s1);
    t = si ? longint'($signed(ai)) - d : longint'($signed(ai)) + d;
    t = clamp(t, s2);
    r = t[31:0];
    s = s1 | s2;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // drive at negedge, check at following negedge
  task automatic step(input logic e, input logic s, input logic [31:0] ai, bi,
                      input logic c, input string req);
    logic [31:0] r;
    logic        sat;
    exec = e; sub = s; a = ai; b = bi; clr = c;
    model(ai, bi, s, r, sat);
    if (e) exp_res = r;
    if (e && sat)  exp_q = 1'b1;
    else if (c)    exp_q = 1'b0;
    @(negedge clk);
    chk({req, " res"}, res, exp_res);
    chk({req, " we"}, {31'd0, we}, {31'd0, e});
    chk({req, " q"}, {31'd0, q}, {31'd0, exp_q});
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240601));
    repeat (2) @(negedge clk);
    chk("R1 res", res, 32'd0);
    chk("R1 we", {31'd0, we}, 32'd0);
    chk("R1 q", {31'd0, q}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 plain add, R4 plain sub
    step(1, 0, 32'd10, 32'd3, 0, "R3");
    chk("R3 value", res, 32'd16);
    step(1, 1, 32'd10, 32'd3, 0, "R4");
    chk("R4 value", res, 32'd4);
    // R2 doubling clamps positive, sum not saturating beyond
    step(1, 0, 32'hC000_0000, 32'h4000_0000, 0, "R2 pos");
    chk("R2 pos value", res, 32'h3FFF_FFFF);
    chk("R8 dbl-only sat", {31'd0, q}, 32'd1);
    step(0, 0, 32'd0, 32'd0, 1, "R9 clr");
    step(1, 0, 32'd0, 32'hBFFF_FFFF, 0, "R2 neg");
    chk("R2 neg value", res, 32'h8000_0000);
    step(0, 0, 32'd0, 32'd0, 1, "R9 clr");
    step(1, 0, 32'd0, 32'hC000_0000, 0, "R2 exact min");
    chk("R2 exact min no q", {31'd0, q}, 32'd0);
    // R5 final clamps
    step(1, 0, 32'h7FFF_FFFF, 32'd1, 0, "R5 add pos");
    chk("R5 add pos value", res, 32'h7FFF_FFFF);
    step(1, 1, 32'h8000_0000, 32'd1, 1, "R9 set wins");
    chk("R5 sub neg value", res, 32'h8000_0000);
    chk("R9 set wins q", {31'd0, q}, 32'd1);
    step(0, 0, 32'd0, 32'd0, 1, "R9 clr");
    step(1, 1, 32'd0, 32'hC000_0000, 0, "R5 sub of min");
    chk("R5 sub of min value", res, 32'h7FFF_FFFF);
    // R7 idle with saturating operands: hold, no q
    step(0, 0, 32'd0, 32'd0, 1, "R9 clr");
    step(0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, "R7 idle");
    chk("R7 idle q", {31'd0, q}, 32'd0);
    chk("R6 idle we", {31'd0, we}, 32'd0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (($urandom % 4) == 0) rb = {rb[31], rb[31], rb[29:0]};
      step(($urandom % 4) != 0, $urandom % 2, ra, rb, ($urandom % 8) == 0, "R3/R4/R8 rnd");
    end
    // R1 async reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 async res", res, 32'd0);
    chk("R1 async q", {31'd0, q}, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule